// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

This block lets a host read or write one 16-bit register inside a multi-device chip on a serial management bus. The host names the target with a 5-bit device address and a 5-bit register address. The block issues the accesses through a plain single-register bus port, which stands in for the serial bit engine. Each bus access is a request held until an acknowledge, and may report an error.

When the configured chip bus address is zero, the chip answers on every bus address. The block then makes one direct access, using the device address as the bus address. Otherwise the chip answers only on its own bus address and exposes two registers there: a command register at offset 0 and a data register at offset 1. The block then runs the command/data handshake. It polls the busy flag of the command register, leaves a programmable gap between polls and gives up after a bounded number of polls. It returns the read data together with a status code.

Top module: `mgmt_indirect_seq`

## Requirements
- R1: With `chip_addr_i` equal to 0, a request makes exactly one bus access to bus address = device address and register = register address, with the request's direction and write data. A read returns the bus read data.
- R2: A command word written to register 0 carries bit 15 = 1 (busy), bit 12 = 1 (clause-22 format), bits 11:10 = opcode (2 = read, 1 = write), bits 9:5 = device address and bits 4:0 = register address. Bits 14:13 are 0.
- R3: An indirect read polls register 0 until bit 15 is clear, writes the read command, polls again until clear, then reads register 1 and returns its value. Every access uses bus address `chip_addr_i`.
- R4: An indirect write polls until bit 15 is clear, writes the data to register 1, writes the write command, then polls until clear.
- R5: If a poll step sees bit 15 set on `POLL_MAX` consecutive polls, the request ends with status 1 (timeout) and no further bus access.
- R6: After a poll that reads busy, the bus request stays low for at least `POLL_GAP` cycles before the next poll.
- R7: An access acknowledged with `bus_err_i` high ends the request at once with status 2 (bus error) and no further bus access.
- R8: `req_ready_o` is high only while no request is in flight. Each accepted request produces exactly one single-cycle `resp_valid_o` pulse, with status 0 on success.
- R9: After reset `req_ready_o` is high and `bus_req_o` and `resp_valid_o` are low.
- R10: While `bus_req_o` waits for `bus_ack_i`, the direction, address, register and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_addr_i | input | 5 | Chip bus address; 0 selects direct access |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_dev_i | input | 5 | Target device address |
| req_reg_i | input | 5 | Target register address |
| req_wdata_i | input | 16 | Write data |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_rdata_o | output | 16 | Read data |
| resp_status_o | output | 2 | 0 ok, 1 timeout, 2 bus error |
| bus_req_o | output | 1 | Bus access request, held until acknowledge |
| bus_write_o | output | 1 | Bus access direction |
| bus_addr_o | output | 5 | Bus address |
| bus_reg_o | output | 5 | Register address on the bus |
| bus_wdata_o | output | 16 | Bus write data |
| bus_ack_i | input | 1 | Bus access complete |
| bus_rdata_i | input | 16 | Bus read data, valid with acknowledge |
| bus_err_i | input | 1 | Bus access failed, valid with acknowledge |

## Verification
Some properties are checked on every cycle. The bus request fields must hold steady until the acknowledge. In indirect mode every access must target the chip address. Every command write must carry the busy and clause-22 bits. An errored acknowledge must be followed at once by the response with the bus idle, and the response must be a lone pulse seen only when the block is idle. Other behaviour shows only through the bench's chip model and scenarios: the access order of reads and writes, and that data written indirectly can be read back. The scenarios also cover the exact number of polls before a timeout, the idle gap between polls, and the point at which an injected error stops the sequence.

// File: rtl/mgmt_seq_pkg.sv
package mgmt_seq_pkg;
  localparam logic [4:0] CMD_REG  = 5'd0;
  localparam logic [4:0] DATA_REG = 5'd1;
  localparam int         BUSY_BIT = 15;

  localparam logic [1:0] OPC_READ  = 2'd2;
  localparam logic [1:0] OPC_WRITE = 2'd1;

  localparam logic [1:0] STS_OK      = 2'd0;
  localparam logic [1:0] STS_TIMEOUT = 2'd1;
  localparam logic [1:0] STS_BUSERR  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_GAP} fsm_e;
  typedef enum logic [2:0] {STEP_POLL, STEP_CMD, STEP_DWR, STEP_DRD, STEP_DIRECT} step_e;
endpackage

// File: rtl/mgmt_cmd_enc.sv
module mgmt_cmd_enc
  import mgmt_seq_pkg::*;
(
  input  logic        write_i,
  input  logic [4:0]  dev_i,
  input  logic [4:0]  reg_i,
  output logic [15:0] cmd_o
);
  always_comb begin
    cmd_o        = '0;
    cmd_o[15]    = 1'b1;
    cmd_o[12]    = 1'b1;
    cmd_o[11:10] = write_i ? OPC_WRITE : OPC_READ;
    cmd_o[9:5]   = dev_i;
    cmd_o[4:0]   = reg_i;
  end
endmodule

// File: rtl/mgmt_poll_timer.sv
module mgmt_poll_timer #(
  parameter int POLL_GAP = 100000,
  parameter int POLL_MAX = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gap_run_i,
  input  logic poll_clr_i,
  input  logic poll_inc_i,
  output logic gap_done_o,
  output logic poll_last_o
);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int CNT_W = $clog2(POLL_MAX + 1);

  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] poll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gap_q <= '0;
    else if (gap_run_i) gap_q <= gap_q + 1'b1;
    else                gap_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         poll_q <= '0;
    else if (poll_clr_i) poll_q <= '0;
    else if (poll_inc_i) poll_q <= poll_q + 1'b1;
  end

  assign gap_done_o  = gap_run_i && (gap_q == GAP_W'(POLL_GAP - 1));
  assign poll_last_o = (poll_q == CNT_W'(POLL_MAX - 1));
endmodule

// File: rtl/mgmt_indirect_seq.sv
module mgmt_indirect_seq
  import mgmt_seq_pkg::*;
#(
  parameter int POLL_GAP = 100000,
  parameter int POLL_MAX = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  chip_addr_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [4:0]  req_dev_i,
  input  logic [4:0]  req_reg_i,
  input  logic [15:0] req_wdata_i,
  output logic        resp_valid_o,
  output logic [15:0] resp_rdata_o,
  output logic [1:0]  resp_status_o,
  output logic        bus_req_o,
  output logic        bus_write_o,
  output logic [4:0]  bus_addr_o,
  output logic [4:0]  bus_reg_o,
  output logic [15:0] bus_wdata_o,
  input  logic        bus_ack_i,
  input  logic [15:0] bus_rdata_i,
  input  logic        bus_err_i
);
  fsm_e        st_q;
  logic [1:0]  idx_q;
  logic        wr_q;
  logic [4:0]  dev_q, reg_q, chip_q;
  logic [15:0] wdata_q, cmd_word;
  step_e       kind;
  logic        direct, last_step, done_ack, poll_busy, gap_done, poll_last;

  mgmt_cmd_enc i_enc (.write_i(wr_q), .dev_i(dev_q), .reg_i(reg_q), .cmd_o(cmd_word));

  assign direct    = (chip_q == 5'd0);
  assign last_step = direct || (idx_q == 2'd3);

  always_comb begin
    if (direct) kind = STEP_DIRECT;
    else begin
      unique case ({wr_q, idx_q})
        3'b000, 3'b010, 3'b100, 3'b111: kind = STEP_POLL;
        3'b001, 3'b110:                 kind = STEP_CMD;
        3'b101:                         kind = STEP_DWR;
        default:                        kind = STEP_DRD;
      endcase
    end
  end

  always_comb begin
    bus_write_o = 1'b0;
    bus_addr_o  = chip_q;
    bus_reg_o   = CMD_REG;
    bus_wdata_o = '0;
    unique case (kind)
      STEP_CMD: begin bus_write_o = 1'b1; bus_wdata_o = cmd_word; end
      STEP_DWR: begin bus_write_o = 1'b1; bus_reg_o = DATA_REG; bus_wdata_o = wdata_q; end
      STEP_DRD: bus_reg_o = DATA_REG;
      STEP_DIRECT: begin
        bus_write_o = wr_q;
        bus_addr_o  = dev_q;
        bus_reg_o   = reg_q;
        bus_wdata_o = wdata_q;
      end
      default: ;
    endcase
  end

  assign bus_req_o   = (st_q == ST_ISSUE);
  assign req_ready_o = (st_q == ST_IDLE);
  assign done_ack    = bus_req_o && bus_ack_i;
  assign poll_busy   = done_ack && !bus_err_i && (kind == STEP_POLL) && bus_rdata_i[BUSY_BIT];

  mgmt_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gap_run_i  (st_q == ST_GAP),
    .poll_clr_i (req_ready_o || (done_ack && !poll_busy)),
    .poll_inc_i (poll_busy),
    .gap_done_o (gap_done),
    .poll_last_o(poll_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      idx_q         <= '0;
      wr_q          <= 1'b0;
      dev_q         <= '0;
      reg_q         <= '0;
      chip_q        <= '0;
      wdata_q       <= '0;
      resp_valid_o  <= 1'b0;
      resp_rdata_o  <= '0;
      resp_status_o <= STS_OK;
    end else begin
      resp_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          st_q    <= ST_ISSUE;
          idx_q   <= '0;
          wr_q    <= req_write_i;
          dev_q   <= req_dev_i;
          reg_q   <= req_reg_i;
          chip_q  <= chip_addr_i;
          wdata_q <= req_wdata_i;
        end
        ST_ISSUE: if (bus_ack_i) begin
          if (bus_err_i) begin
            st_q          <= ST_IDLE;
            resp_valid_o  <= 1'b1;
            resp_status_o <= STS_BUSERR;
          end else if (poll_busy) begin
            if (poll_last) begin
              st_q          <= ST_IDLE;
              resp_valid_o  <= 1'b1;
              resp_status_o <= STS_TIMEOUT;
            end else st_q <= ST_GAP;
          end else begin
            if (kind == STEP_DRD || (kind == STEP_DIRECT && !wr_q)) resp_rdata_o <= bus_rdata_i;
            if (last_step) begin
              st_q          <= ST_IDLE;
              resp_valid_o  <= 1'b1;
              resp_status_o <= STS_OK;
            end else idx_q <= idx_q + 2'd1;
          end
        end
        ST_GAP: if (gap_done) st_q <= ST_ISSUE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mgmt_indirect_seq_chk.sv
module mgmt_indirect_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  chip_addr_i,
  input logic        req_ready_o,
  input logic        resp_valid_o,
  input logic        bus_req_o,
  input logic        bus_write_o,
  input logic [4:0]  bus_addr_o,
  input logic [4:0]  bus_reg_o,
  input logic [15:0] bus_wdata_o,
  input logic        bus_ack_i,
  input logic        bus_err_i
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_write_o) && $stable(bus_addr_o)
                                   && $stable(bus_reg_o) && $stable(bus_wdata_o))); // R10

  AST_INDIRECT_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && chip_addr_i != 5'd0) |-> (bus_addr_o == chip_addr_i && bus_reg_o <= 5'd1)); // R3

  AST_CMD_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_write_o && chip_addr_i != 5'd0 && bus_reg_o == 5'd0)
      |-> (bus_wdata_o[15] && bus_wdata_o[12] && bus_wdata_o[14:13] == 2'b00
           && bus_wdata_o[11:10] != 2'b00 && bus_wdata_o[11:10] != 2'b11)); // R2

  AST_ERR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i && bus_err_i) |=> (resp_valid_o && !bus_req_o)); // R7

  AST_RESP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o); // R8

  AST_RESP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (req_ready_o && !bus_req_o)); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !req_ready_o); // R8
endmodule

bind mgmt_indirect_seq mgmt_indirect_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chip_addr_i (chip_addr_i),
  .req_ready_o (req_ready_o),
  .resp_valid_o(resp_valid_o),
  .bus_req_o   (bus_req_o),
  .bus_write_o (bus_write_o),
  .bus_addr_o  (bus_addr_o),
  .bus_reg_o   (bus_reg_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .bus_err_i   (bus_err_i)
);

// File: tb/test_mgmt_indirect_seq.sv
`timescale 1ns/1ps
module test_mgmt_indirect_seq;
  localparam int GAP = 4;
  localparam int PMAX = 100;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  chip_addr = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_dev = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, resp_valid;
  logic [15:0] resp_rdata;
  logic [1:0]  resp_status;
  logic        bus_req, bus_write;
  logic [4:0]  bus_addr, bus_reg;
  logic [15:0] bus_wdata;
  logic        bus_ack, bus_err;
  logic [15:0] bus_rdata;

  always #5 clk = ~clk;

  mgmt_indirect_seq #(.POLL_GAP(GAP), .POLL_MAX(PMAX)) i_mgmt_indirect_seq (
    .clk_i(clk), .rst_ni(rst_n), .chip_addr_i(chip_addr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_dev_i(req_dev), .req_reg_i(req_reg), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata), .resp_status_o(resp_status),
    .bus_req_o(bus_req), .bus_write_o(bus_write), .bus_addr_o(bus_addr),
    .bus_reg_o(bus_reg), .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack),
    .bus_rdata_i(bus_rdata), .bus_err_i(bus_err));

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 16'h1357) ^ 16'hA5A5;
  endfunction

  // chip model controls (bench-owned)
  bit stuck_busy = 1'b0;
  int inj_target = -1;
  int busy_per_cmd = 1;

  // chip model state (model-owned)
  logic [15:0] mem [1024];
  logic [15:0] data_reg;
  int busy_left, acc_cnt, poll_cnt, direct_cnt, order_viol, fmt_viol, stab_viol;
  int gap_viol, gaps_seen, idle_run, lat;
  bit prev_busy_poll, held;
  logic [31:0] saved;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
      for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
      data_reg = '0; busy_left = 2; acc_cnt = 0; poll_cnt = 0; direct_cnt = 0;
      order_viol = 0; fmt_viol = 0; stab_viol = 0; gap_viol = 0; gaps_seen = 0;
      idle_run = 0; lat = 0; prev_busy_poll = 1'b0; held = 1'b0; saved = '0;
    end else begin
      if (held && bus_req && saved != {bus_write, bus_addr, bus_reg, bus_wdata}) stab_viol++;
      held  = bus_req && !bus_ack;
      saved = {bus_write, bus_addr, bus_reg, bus_wdata};
      if (bus_req) begin
        if (idle_run > 0 && prev_busy_poll) begin
          gaps_seen++;
          if (idle_run < GAP) gap_viol++;
        end
        idle_run = 0;
      end else idle_run++;
      if (bus_ack) begin
        bus_ack <= 1'b0; bus_err <= 1'b0; lat = 0;
      end else if (bus_req) begin
        if (lat == 1) begin
          lat = 0;
          acc_cnt++;
          bus_ack <= 1'b1;
          bus_rdata <= '0;
          if (acc_cnt == inj_target) begin
            bus_err <= 1'b1;
            prev_busy_poll = 1'b0;
          end else begin
            bus_err <= 1'b0;
            prev_busy_poll = 1'b0;
            if (chip_addr == 5'd0) begin
              direct_cnt++;
              if (bus_write) mem[{bus_addr, bus_reg}] = bus_wdata;
              else bus_rdata <= mem[{bus_addr, bus_reg}];
            end else if (bus_addr != chip_addr || bus_reg > 5'd1) begin
              order_viol++;
            end else if (bus_reg == 5'd0 && !bus_write) begin
              poll_cnt++;
              bus_rdata <= {(busy_left > 0 || stuck_busy), 15'h0};
              prev_busy_poll = (busy_left > 0 || stuck_busy);
              if (busy_left > 0) busy_left--;
            end else if (bus_reg == 5'd0) begin
              if (busy_left > 0) order_viol++;
              if (!bus_wdata[15] || !bus_wdata[12] || bus_wdata[14:13] != 2'b00) fmt_viol++;
              if (bus_wdata[11:10] == 2'd2) data_reg = mem[bus_wdata[9:0]];
              else if (bus_wdata[11:10] == 2'd1) mem[bus_wdata[9:0]] = data_reg;
              else fmt_viol++;
              busy_left = busy_per_cmd;
            end else if (bus_write) begin
              if (busy_left > 0) order_viol++;
              data_reg = bus_wdata;
            end else begin
              if (busy_left > 0) order_viol++;
              bus_rdata <= data_reg;
            end
          end
        end else lat++;
      end
    end
  end

  // scoreboard
  typedef struct { bit chk_data; logic [15:0] data; logic [1:0] sts; string rq; } exp_t;
  exp_t sb_q[$];
  int resp_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      resp_cnt++;
      if (sb_q.size() == 0) check(1'b0, "R8 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(resp_status == e.sts, e.rq, resp_status, e.sts);
        if (e.chk_data) check(resp_rdata == e.data, e.rq, resp_rdata, e.data);
      end
    end
  end

  logic [15:0] shadow [1024];

  task automatic issue(input bit wr, input logic [4:0] dev, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [1:0] sts, input bit chk, input string rq);
    exp_t e;
    e.chk_data = chk && !wr && sts == 2'd0;
    e.data = shadow[{dev, rg}];
    e.sts = sts;
    e.rq = rq;
    if (wr && sts == 2'd0) shadow[{dev, rg}] = wd;
    sb_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dev = dev; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access(input bit wr, input logic [4:0] dev, input logic [4:0] rg,
                        input logic [15:0] wd, input logic [1:0] sts, input string rq);
    issue(wr, dev, rg, wd, sts, 1'b1, rq);
    wait_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d0, p0, a0, n_req;
    for (int i = 0; i < 1024; i++) shadow[i] = init_val(i);
    n_req = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    check(bus_req == 1'b0, "R9 bus idle after reset", bus_req, 0);
    check(resp_valid == 1'b0, "R9 no response in reset", resp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 direct mode
    d0 = direct_cnt;
    access(1'b1, 5'd3, 5'd5, 16'hBEEF, 2'd0, "R1 direct write"); n_req++;
    check(direct_cnt - d0 == 1, "R1 single direct access", direct_cnt - d0, 1);
    access(1'b0, 5'd3, 5'd5, 16'h0, 2'd0, "R1 direct read back"); n_req++;
    access(1'b0, 5'd7, 5'd1, 16'h0, 2'd0, "R1 direct read preset"); n_req++;

    // R3 indirect read
    chip_addr = 5'h12;
    access(1'b0, 5'd4, 5'd9, 16'h0, 2'd0, "R3 indirect read"); n_req++;
    check(order_viol == 0, "R3 access order", order_viol, 0);
    check(fmt_viol == 0, "R2 command format", fmt_viol, 0);

    // R4 indirect write and read back
    access(1'b1, 5'd10, 5'd2, 16'h1234, 2'd0, "R4 indirect write"); n_req++;
    access(1'b0, 5'd10, 5'd2, 16'h0, 2'd0, "R4 indirect read back"); n_req++;
    busy_per_cmd = 3;
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 5'(i * 5 + 1), 5'(i + 3), 16'hA000 + 16'(i * 16'h0111), 2'd0, "R4 pattern write"); n_req++;
      access(1'b0, 5'(i * 5 + 1), 5'(i + 3), 16'h0, 2'd0, "R2 pattern read"); n_req++;
    end
    check(order_viol == 0, "R4 access order", order_viol, 0);
    check(fmt_viol == 0, "R2 command format all", fmt_viol, 0);

    // R8 not ready while in flight
    issue(1'b0, 5'd2, 5'd2, 16'h0, 2'd0, 1'b1, "R8 busy read"); n_req++;
    @(negedge clk);
    check(req_ready == 1'b0, "R8 ready low in flight", req_ready, 0);
    wait_done();

    // R5 timeout
    stuck_busy = 1'b1;
    p0 = poll_cnt; a0 = acc_cnt;
    access(1'b0, 5'd6, 5'd6, 16'h0, 2'd1, "R5 timeout status"); n_req++;
    check(poll_cnt - p0 == PMAX, "R5 poll count", poll_cnt - p0, PMAX);
    check(acc_cnt - a0 == PMAX, "R5 nothing after timeout", acc_cnt - a0, PMAX);
    stuck_busy = 1'b0;

    // R6 gap between busy polls
    check(gap_viol == 0, "R6 poll gap", gap_viol, 0);
    check(gaps_seen > 0, "R6 gaps observed", gaps_seen, 1);

    // R7 bus error on command write
    busy_per_cmd = 1;
    a0 = acc_cnt;
    inj_target = acc_cnt + 2;
    access(1'b0, 5'd8, 5'd8, 16'h0, 2'd2, "R7 error status"); n_req++;
    check(acc_cnt - a0 == 2, "R7 abort after error", acc_cnt - a0, 2);
    inj_target = -1;
    access(1'b0, 5'd8, 5'd8, 16'h0, 2'd0, "R7 recovery read"); n_req++;

    // R7 direct-mode error leaves target unchanged
    chip_addr = 5'd0;
    inj_target = acc_cnt + 1;
    access(1'b1, 5'd9, 5'd9, 16'h5555, 2'd2, "R7 direct error"); n_req++;
    inj_target = -1;
    access(1'b0, 5'd9, 5'd9, 16'h0, 2'd0, "R7 direct unchanged"); n_req++;

    repeat (5) @(negedge clk);
    check(resp_cnt == n_req, "R8 one response per request", resp_cnt, n_req);
    check(stab_viol == 0, "R10 fields held", stab_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule